// File: doc/BRIEF.md
# DDR SDRAM Command Monitor

This block sits beside the command bus of a four-bank DDR SDRAM and samples it on every rising clock edge. It turns the clock-enable pair, chip select, the three strobe lines, the two bank bits and the address word into a single named command. The decoded command, target bank, all-banks flag, auto-precharge flag and the relevant row or column address appear combinationally in the same cycle.

Alongside the decode, the block models the device state that the command rules depend on: which banks hold an open row, whether a burst is running and whether it carries a write auto-precharge, how long ago a mode-register write happened, a per-bank precharge-to-activate window after an auto-precharge, and whether the device sits in self-refresh. Each kind of illegal command sequence sets its own sticky flag, which clears only on reset.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With clock-enable high in the previous and current cycle, `cmd_code` reports: chip select high → 0 (deselect); chip select low with RAS,CAS,WE = 111 → 1 (NOP), 000 with bank bit 0 low → 2 (mode write), 000 with bank bit 0 high → 3 (extended mode write), 001 → 4 (refresh), 010 → 9 (precharge), 011 → 10 (activate), 100 → 11 (write), 101 → 12 (read), 110 → 13 (burst stop).
- R2: Clock-enable high then low gives 5 (self-refresh entry) for a refresh pattern and 7 (power-down entry) for NOP or deselect; low then high gives 6 (self-refresh exit) while in self-refresh, otherwise 8 (power-down exit).
- R3: For precharge, address bit 10 high raises `cmd_all_banks`; refresh and self-refresh entry also raise it. Activate, precharge, read and write put the bank bits on `cmd_bank` (00 bank A, 01 B, 10 C, 11 D).
- R4: Read and write raise `cmd_auto_pre` when address bit 10 is high and drive bits 9..0 of the address on `cmd_addr` with upper bits zero; activate drives the whole row address.
- R5: Activate marks its bank open in `bank_open` from the next cycle; single precharge closes its bank; precharge with bit 10 high closes all banks.
- R6: A mode or extended mode write while any bank is open sets `viol_mode_state`.
- R7: With the default gap of 2 cycles, any command other than NOP or deselect in the cycle right after a mode write sets `viol_mode_gap`; a command two cycles after is legal.
- R8: Refresh or self-refresh entry while any bank is open sets `viol_ref_state`.
- R9: A write with auto-precharge runs a burst of BURST_LEN/2 cycles (2 by default); a read or write in those cycles sets `viol_wap_rdwr`. A read with auto-precharge does not block later reads or writes.
- R10: An auto-precharge closes its bank after the burst (open through the cycle after the command plus one, closed from command + 3); an activate to that bank earlier than command + BURST_LEN/2 + TRP_CYC + 1 (cycle +6 by default) sets `viol_act_trp`.
- R11: A burst stop ends the running burst: a pending auto-precharge bank closes at once and a read or write in the next cycle is legal.
- R12: After reset all flags are low and all banks closed; once set, a violation flag stays high until reset.
- R13: Clock-enable low in the current cycle with any pattern other than those in R2, including while it stays low, decodes as 1 (NOP) and changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_prev | input | 1 | Clock-enable seen in the previous cycle |
| cke | input | 1 | Clock-enable in the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row/column address, bit 10 is the auto-precharge / all-banks bit |
| cmd_code | output | 4 | Decoded command code (R1, R2) |
| cmd_bank | output | 2 | Target bank for bank-addressed commands, else 0 |
| cmd_all_banks | output | 1 | Command targets every bank |
| cmd_auto_pre | output | 1 | Read/write requests auto-precharge |
| cmd_addr | output | 12 | Row address for activate, column for read/write, else 0 |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| viol_mode_state | output | 1 | Sticky: mode write with a bank open |
| viol_mode_gap | output | 1 | Sticky: command too soon after a mode write |
| viol_ref_state | output | 1 | Sticky: refresh with a bank open |
| viol_wap_rdwr | output | 1 | Sticky: read/write during a write auto-precharge burst |
| viol_act_trp | output | 1 | Sticky: activate inside the precharge window |

## Verification
A wrong bank-state bit shows up in `bank_open` in the very next cycle and then as a false or missing mode or refresh violation on the next such command. A burst counter off by one moves the cycle at which `viol_wap_rdwr` stops firing and the cycle at which the auto-precharged bank reads closed, so the bench probes both edges of that window. A wrong precharge-window load shifts the first legal activate by a cycle, caught by activating one cycle before and exactly at the boundary.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL    = 4'd0,
    CMD_NOP      = 4'd1,
    CMD_MRS      = 4'd2,
    CMD_EMRS     = 4'd3,
    CMD_REF      = 4'd4,
    CMD_SREF_IN  = 4'd5,
    CMD_SREF_OUT = 4'd6,
    CMD_PDN_IN   = 4'd7,
    CMD_PDN_OUT  = 4'd8,
    CMD_PRE      = 4'd9,
    CMD_ACT      = 4'd10,
    CMD_WR       = 4'd11,
    CMD_RD       = 4'd12,
    CMD_BST      = 4'd13
  } cmd_e;

  // Clock cycles occupied by a burst of the given beat count (two beats a cycle).
  function automatic int beat_cycles(input int beats);
    return (beats + 1) / 2;
  endfunction

  function automatic logic is_idle(input cmd_e c);
    return (c == CMD_NOP) || (c == CMD_DESEL);
  endfunction

  // One cycle of bus pins to a command.
  function automatic cmd_e decode_cmd(input logic cke_p, input logic cke_c,
                                      input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n,
                                      input logic ba0, input logic in_sref);
    logic [2:0] rcw;
    cmd_e       res;
    rcw = {ras_n, cas_n, we_n};
    res = CMD_NOP;
    if (!cke_p && cke_c) begin
      res = in_sref ? CMD_SREF_OUT : CMD_PDN_OUT;
    end else if (!cke_c) begin
      if (cke_p) begin
        if (cs_n || rcw == 3'b111) res = CMD_PDN_IN;
        else if (rcw == 3'b001)    res = CMD_SREF_IN;
      end
    end else if (cs_n) begin
      res = CMD_DESEL;
    end else begin
      case (rcw)
        3'b000:  res = ba0 ? CMD_EMRS : CMD_MRS;
        3'b001:  res = CMD_REF;
        3'b010:  res = CMD_PRE;
        3'b011:  res = CMD_ACT;
        3'b100:  res = CMD_WR;
        3'b101:  res = CMD_RD;
        3'b110:  res = CMD_BST;
        default: res = CMD_NOP;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int COL_W  = 10,
  parameter int BA_W   = 2
) (
  input  logic              cke_prev,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              in_sref,
  output cmd_e              cmd,
  output logic [BA_W-1:0]   bank,
  output logic              all_banks,
  output logic              auto_pre,
  output logic [ADDR_W-1:0] addr_out
);

  logic ap_bit;
  logic is_rdwr;
  logic bank_cmd;

  assign ap_bit = addr[AP_BIT];

  always_comb begin
    cmd      = decode_cmd(cke_prev, cke, cs_n, ras_n, cas_n, we_n, ba[0], in_sref);
    is_rdwr  = (cmd == CMD_RD) || (cmd == CMD_WR);
    bank_cmd = is_rdwr || (cmd == CMD_ACT) || (cmd == CMD_PRE);
    bank     = bank_cmd ? ba : '0;
    all_banks = ((cmd == CMD_PRE) && ap_bit) || (cmd == CMD_REF) || (cmd == CMD_SREF_IN);
    auto_pre  = is_rdwr && ap_bit;
    if (cmd == CMD_ACT)  addr_out = addr;
    else if (is_rdwr)    addr_out = {{(ADDR_W-COL_W){1'b0}}, addr[COL_W-1:0]};
    else                 addr_out = '0;
  end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int TMR_LOAD  = 5,
  localparam int TMR_W    = $clog2(TMR_LOAD + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] open_req,
  input  logic [NUM_BANKS-1:0] close_req,
  input  logic [NUM_BANKS-1:0] tmr_load,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] tmr_busy
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[g] <= 1'b0;
        tmr          <= '0;
      end else begin
        if (open_req[g])       bank_open[g] <= 1'b1;
        else if (close_req[g]) bank_open[g] <= 1'b0;
        if (tmr_load[g])       tmr <= TMR_W'(TMR_LOAD);
        else if (tmr != '0)    tmr <= tmr - 1'b1;
      end
    end

    assign tmr_busy[g] = (tmr != '0);

    // R5
    bank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_req[g] |=> bank_open[g]);

    // R5
    bank_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (close_req[g] && !open_req[g]) |=> !bank_open[g]);
  end

endmodule

// File: rtl/ddr_burst_tracker.sv
module ddr_burst_tracker #(
  parameter int BURST_CYC = 2,
  parameter int BA_W      = 2,
  localparam int CNT_W    = $clog2(BURST_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_rdwr,
  input  logic            is_write,
  input  logic            is_bst,
  input  logic            auto_pre,
  input  logic [BA_W-1:0] bank,
  output logic            burst_active,
  output logic            wap_active,
  output logic            close_evt,
  output logic [BA_W-1:0] close_bank
);

  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             pend_wr;

  assign burst_active = (cnt != '0);
  assign wap_active   = burst_active && pend && pend_wr;
  // Pending auto-precharge retires at the last burst cycle, or when cut short.
  assign close_evt    = pend && burst_active && ((cnt == CNT_W'(1)) || is_bst || is_rdwr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      pend       <= 1'b0;
      pend_wr    <= 1'b0;
      close_bank <= '0;
    end else if (is_rdwr) begin
      cnt        <= CNT_W'(BURST_CYC);
      pend       <= auto_pre;
      pend_wr    <= is_write;
      close_bank <= bank;
    end else if (is_bst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (burst_active) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) pend <= 1'b0;
    end
  end

  // R11
  bst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_bst |=> !burst_active);

  // R9
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> $past(is_rdwr));

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int COL_W     = 10,
  parameter int BURST_LEN = 4,
  parameter int TRP_CYC   = 3,
  parameter int MRD_CYC   = 2,
  localparam int BA_W      = $clog2(NUM_BANKS),
  localparam int BURST_CYC = beat_cycles(BURST_LEN),
  localparam int TMR_LOAD  = BURST_CYC + TRP_CYC,
  localparam int MRD_W     = $clog2(MRD_CYC + 1),
  localparam int NUM_VIOL  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke_prev,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [3:0]           cmd_code,
  output logic [BA_W-1:0]      cmd_bank,
  output logic                 cmd_all_banks,
  output logic                 cmd_auto_pre,
  output logic [ADDR_W-1:0]    cmd_addr,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 viol_mode_state,
  output logic                 viol_mode_gap,
  output logic                 viol_ref_state,
  output logic                 viol_wap_rdwr,
  output logic                 viol_act_trp
);

  cmd_e                 cmd;
  logic                 in_sref;
  logic [MRD_W-1:0]     mrd_cnt;
  logic                 is_rdwr, is_mode, is_act;
  logic [NUM_BANKS-1:0] sel_bank, sel_close_ap;
  logic [NUM_BANKS-1:0] open_req, close_req, tmr_load, tmr_busy;
  logic                 burst_active, wap_active, close_evt;
  logic [BA_W-1:0]      close_bank;
  logic [NUM_VIOL-1:0]  viol_evt, viol_q;

  ddr_cmd_decode #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .COL_W(COL_W), .BA_W(BA_W)) u_decode (
    .cke_prev (cke_prev), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .in_sref (in_sref),
    .cmd (cmd), .bank (cmd_bank), .all_banks (cmd_all_banks),
    .auto_pre (cmd_auto_pre), .addr_out (cmd_addr)
  );

  assign cmd_code = cmd;
  assign is_rdwr  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_mode  = (cmd == CMD_MRS) || (cmd == CMD_EMRS);
  assign is_act   = (cmd == CMD_ACT);

  assign sel_bank     = {{(NUM_BANKS-1){1'b0}}, 1'b1} << cmd_bank;
  assign sel_close_ap = {{(NUM_BANKS-1){1'b0}}, 1'b1} << close_bank;
  assign open_req     = is_act ? sel_bank : '0;
  assign tmr_load     = (is_rdwr && cmd_auto_pre) ? sel_bank : '0;
  assign close_req    = ((cmd == CMD_PRE) ? (cmd_all_banks ? '1 : sel_bank) : '0)
                      | (close_evt ? sel_close_ap : '0);

  ddr_burst_tracker #(.BURST_CYC(BURST_CYC), .BA_W(BA_W)) u_burst (
    .clk (clk), .rst_n (rst_n), .is_rdwr (is_rdwr), .is_write (cmd == CMD_WR),
    .is_bst (cmd == CMD_BST), .auto_pre (cmd_auto_pre), .bank (cmd_bank),
    .burst_active (burst_active), .wap_active (wap_active),
    .close_evt (close_evt), .close_bank (close_bank)
  );

  ddr_bank_tracker #(.NUM_BANKS(NUM_BANKS), .TMR_LOAD(TMR_LOAD)) u_banks (
    .clk (clk), .rst_n (rst_n), .open_req (open_req), .close_req (close_req),
    .tmr_load (tmr_load), .bank_open (bank_open), .tmr_busy (tmr_busy)
  );

  // Violation events, one bit each, ordered as the outputs below.
  assign viol_evt[0] = is_mode && (|bank_open);
  assign viol_evt[1] = (mrd_cnt != '0) && !is_idle(cmd);
  assign viol_evt[2] = ((cmd == CMD_REF) || (cmd == CMD_SREF_IN)) && (|bank_open);
  assign viol_evt[3] = is_rdwr && wap_active;
  assign viol_evt[4] = is_act && tmr_busy[cmd_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrd_cnt <= '0;
      in_sref <= 1'b0;
      viol_q  <= '0;
    end else begin
      viol_q <= viol_q | viol_evt;
      if (is_mode)              mrd_cnt <= MRD_W'(MRD_CYC - 1);
      else if (mrd_cnt != '0)   mrd_cnt <= mrd_cnt - 1'b1;
      if (cmd == CMD_SREF_IN)       in_sref <= 1'b1;
      else if (cmd == CMD_SREF_OUT) in_sref <= 1'b0;
    end
  end

  assign viol_mode_state = viol_q[0];
  assign viol_mode_gap   = viol_q[1];
  assign viol_ref_state  = viol_q[2];
  assign viol_wap_rdwr   = viol_q[3];
  assign viol_act_trp    = viol_q[4];

  for (genvar v = 0; v < NUM_VIOL; v++) begin : g_sticky
    // R12
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_q[v] |=> viol_q[v]);
  end

  // R7
  mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mrd_cnt != '0) && !is_idle(cmd)) |=> viol_mode_gap);

  // R10
  act_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && tmr_busy[cmd_bank]) |=> viol_act_trp);

endmodule

// File: tb/ddr_cmd_monitor_tb.sv
module ddr_cmd_monitor_tb;

  localparam int C_DESEL = 0, C_NOP = 1, C_MRS = 2, C_EMRS = 3, C_REF = 4;
  localparam int C_SIN = 5, C_SOUT = 6, C_PIN = 7, C_POUT = 8, C_PRE = 9;
  localparam int C_ACT = 10, C_WR = 11, C_RD = 12, C_BST = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_prev = 1'b1, cke = 1'b1, cs_n = 1'b1;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic        cmd_all_banks, cmd_auto_pre;
  logic [11:0] cmd_addr;
  logic [3:0]  bank_open;
  logic        viol_mode_state, viol_mode_gap, viol_ref_state, viol_wap_rdwr, viol_act_trp;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ddr_cmd_monitor u_dut (
    .clk (clk), .rst_n (rst_n), .cke_prev (cke_prev), .cke (cke), .cs_n (cs_n),
    .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr),
    .cmd_code (cmd_code), .cmd_bank (cmd_bank), .cmd_all_banks (cmd_all_banks),
    .cmd_auto_pre (cmd_auto_pre), .cmd_addr (cmd_addr), .bank_open (bank_open),
    .viol_mode_state (viol_mode_state), .viol_mode_gap (viol_mode_gap),
    .viol_ref_state (viol_ref_state), .viol_wap_rdwr (viol_wap_rdwr),
    .viol_act_trp (viol_act_trp)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic pk, input logic ck, input logic cs, input logic r,
                     input logic c, input logic w, input logic [1:0] b, input logic [11:0] a);
    cke_prev = pk; cke = ck; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic nop();               put(1,1,0,1,1,1,2'd0,12'd0); tick(); endtask
  task automatic act(input logic [1:0] b);
    put(1,1,0,0,1,1,b,12'h123); tick();
  endtask
  task automatic pre(input logic [1:0] b, input logic all);
    put(1,1,0,0,1,0,b,{1'b0,all,10'd0}); tick();
  endtask
  task automatic wr(input logic [1:0] b, input logic ap);
    put(1,1,0,1,0,0,b,{1'b0,ap,10'h011}); tick();
  endtask
  task automatic rd(input logic [1:0] b, input logic ap);
    put(1,1,0,1,0,1,b,{1'b0,ap,10'h022}); tick();
  endtask
  task automatic mrs(input logic ext);
    put(1,1,0,0,0,0,{1'b0,ext},12'h031); tick();
  endtask
  task automatic refr();              put(1,1,0,0,0,1,2'd0,12'd0); tick(); endtask
  task automatic bst();               put(1,1,0,1,1,0,2'd0,12'd0); tick(); endtask

  task automatic do_reset();
    rst_n = 1'b0;
    put(1,1,1,1,1,1,2'd0,12'd0);
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R12 banks closed", bank_open, 0);
    chk("R12 flags clear", {viol_mode_state, viol_mode_gap, viol_ref_state,
                            viol_wap_rdwr, viol_act_trp}, 0);
    chk("R1 deselect idle", cmd_code, C_DESEL);
  endtask

  task automatic t_decode();
    rst_n = 1'b0;
    put(1,1,1,0,0,0,2'd0,12'd0); chk("R1 deselect", cmd_code, C_DESEL);
    put(1,1,0,1,1,1,2'd0,12'd0); chk("R1 nop", cmd_code, C_NOP);
    put(1,1,0,0,0,0,2'd0,12'd0); chk("R1 mode write", cmd_code, C_MRS);
    put(1,1,0,0,0,0,2'd1,12'd0); chk("R1 ext mode write", cmd_code, C_EMRS);
    put(1,1,0,0,0,1,2'd0,12'd0); chk("R1 refresh", cmd_code, C_REF);
    put(1,1,0,0,1,0,2'd0,12'd0); chk("R1 precharge", cmd_code, C_PRE);
    put(1,1,0,0,1,1,2'd0,12'd0); chk("R1 activate", cmd_code, C_ACT);
    put(1,1,0,1,0,0,2'd0,12'd0); chk("R1 write", cmd_code, C_WR);
    put(1,1,0,1,0,1,2'd0,12'd0); chk("R1 read", cmd_code, C_RD);
    put(1,1,0,1,1,0,2'd0,12'd0); chk("R1 burst stop", cmd_code, C_BST);
    put(1,0,1,0,0,0,2'd0,12'd0); chk("R2 power-down entry", cmd_code, C_PIN);
    put(1,0,0,0,0,1,2'd0,12'd0); chk("R2 self-refresh entry", cmd_code, C_SIN);
    put(0,1,0,0,1,1,2'd0,12'd0); chk("R2 power-down exit", cmd_code, C_POUT);
    put(0,0,0,0,1,1,2'd0,12'd0); chk("R13 held low", cmd_code, C_NOP);
    put(1,0,0,0,1,1,2'd0,12'd0); chk("R13 entry with activate", cmd_code, C_NOP);
    do_reset();
  endtask

  task automatic t_fields();
    rst_n = 1'b0;
    put(1,1,0,0,1,0,2'd1,12'h400); chk("R3 precharge all", cmd_all_banks, 1);
    put(1,1,0,0,1,0,2'd2,12'h000); chk("R3 single precharge flag", cmd_all_banks, 0);
    chk("R3 single precharge bank", cmd_bank, 2);
    put(1,1,0,0,0,1,2'd0,12'h000); chk("R3 refresh all", cmd_all_banks, 1);
    put(1,1,0,1,0,1,2'd3,12'hD55); chk("R4 read auto-pre", cmd_auto_pre, 1);
    chk("R4 read column", cmd_addr, 12'h155);
    chk("R3 read bank", cmd_bank, 3);
    put(1,1,0,1,0,0,2'd0,12'h0AA); chk("R4 write no auto-pre", cmd_auto_pre, 0);
    put(1,1,0,0,1,1,2'd1,12'hABC); chk("R4 activate row", cmd_addr, 12'hABC);
    do_reset();
  endtask

  task automatic t_bank_state();
    do_reset();
    act(2'd1); chk("R5 open bank B", bank_open, 4'b0010);
    act(2'd3); chk("R5 open bank D", bank_open, 4'b1010);
    pre(2'd1, 1'b0); chk("R5 single precharge", bank_open, 4'b1000);
    act(2'd0); chk("R5 open bank A", bank_open, 4'b1001);
    pre(2'd2, 1'b1); chk("R5 precharge all", bank_open, 4'b0000);
  endtask

  task automatic t_mode_rules();
    do_reset();
    mrs(1'b0); chk("R6 mode write banks closed", viol_mode_state, 0);
    nop(); act(2'd0); chk("R7 command at gap end", viol_mode_gap, 0);
    do_reset();
    mrs(1'b1); act(2'd0); chk("R7 command inside gap", viol_mode_gap, 1);
    nop(); nop(); nop(); chk("R12 gap flag sticky", viol_mode_gap, 1);
    do_reset();
    act(2'd2); mrs(1'b0); chk("R6 mode write bank open", viol_mode_state, 1);
  endtask

  task automatic t_refresh_rules();
    do_reset();
    act(2'd0); refr(); chk("R8 refresh bank open", viol_ref_state, 1);
    do_reset();
    act(2'd1); put(1,0,0,0,0,1,2'd0,12'd0); tick();
    chk("R8 self-refresh entry bank open", viol_ref_state, 1);
    do_reset();
    put(1,0,0,0,0,1,2'd0,12'd0); chk("R2 self-refresh entry", cmd_code, C_SIN); tick();
    chk("R8 self-refresh banks closed", viol_ref_state, 0);
    put(0,0,1,1,1,1,2'd0,12'd0); chk("R13 held low in self-refresh", cmd_code, C_NOP); tick();
    put(0,1,1,1,1,1,2'd0,12'd0); chk("R2 self-refresh exit", cmd_code, C_SOUT); tick();
    put(1,0,1,1,1,1,2'd0,12'd0); tick();
    put(0,1,1,1,1,1,2'd0,12'd0); chk("R2 exit after power-down", cmd_code, C_POUT); tick();
  endtask

  task automatic t_write_ap();
    do_reset();
    act(2'd0); act(2'd1); wr(2'd0, 1'b1); rd(2'd1, 1'b0);
    chk("R9 read right after write auto-pre", viol_wap_rdwr, 1);
    do_reset();
    act(2'd0); act(2'd1); wr(2'd0, 1'b1); nop(); wr(2'd1, 1'b0);
    chk("R9 write in last burst cycle", viol_wap_rdwr, 1);
    do_reset();
    act(2'd0); act(2'd1); wr(2'd0, 1'b1); nop(); nop(); rd(2'd1, 1'b0);
    chk("R9 read after burst end", viol_wap_rdwr, 0);
    do_reset();
    act(2'd0); act(2'd1); rd(2'd0, 1'b1); rd(2'd1, 1'b0);
    chk("R9 read auto-pre no block", viol_wap_rdwr, 0);
  endtask

  task automatic t_trp();
    do_reset();
    act(2'd0); wr(2'd0, 1'b1);
    nop(); chk("R10 bank open during burst", bank_open[0], 1);
    nop(); chk("R10 bank closed after burst", bank_open[0], 0);
    nop(); nop(); act(2'd0); chk("R10 activate one cycle early", viol_act_trp, 1);
    do_reset();
    act(2'd0); wr(2'd0, 1'b1);
    for (int i = 0; i < 5; i++) nop();
    act(2'd0);
    chk("R10 activate at window end", viol_act_trp, 0);
    chk("R10 bank reopened", bank_open[0], 1);
  endtask

  task automatic t_burst_stop();
    do_reset();
    act(2'd0); act(2'd1); wr(2'd0, 1'b1); bst();
    chk("R11 burst stop closes pending bank", bank_open, 4'b0010);
    rd(2'd1, 1'b0); chk("R11 read after burst stop", viol_wap_rdwr, 0);
  endtask

  task automatic t_cke_low();
    do_reset();
    put(0,0,0,0,1,1,2'd0,12'd0); chk("R13 activate with clock-enable low", cmd_code, C_NOP); tick();
    put(0,1,1,1,1,1,2'd0,12'd0); tick();
    put(1,0,0,0,1,1,2'd2,12'd0); tick();
    put(0,1,1,1,1,1,2'd0,12'd0); tick();
    nop();
    chk("R13 no bank opened", bank_open, 0);
    chk("R13 no flags", {viol_mode_state, viol_mode_gap, viol_ref_state,
                         viol_wap_rdwr, viol_act_trp}, 0);
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick();
    t_reset_state();
    t_decode();
    t_fields();
    t_bank_state();
    t_mode_rules();
    t_refresh_rules();
    t_write_ap();
    t_trp();
    t_burst_stop();
    t_cke_low();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule